// File: doc/BRIEF.md
# Hysteresis Threshold Parameter Controller

This block keeps two threshold pairs, a switch-off (low) level and a switch-on (high) level, one pair for the ground-open sensing mode and one for the supply-open sensing mode. A host asks to move one threshold of one mode with a single-cycle strobe. The block checks the request against the legal ranges and the minimum separation. It then stores the new value and corrects the opposite threshold by one volt where needed, so that the separation stays even. Each accepted change produces a 16-bit configuration word for the mode that changed. The upper byte of the word is the separation (high minus low) and the lower byte is the sum (high plus low), which is twice the centre.

A comparator array applies the stored thresholds, with hysteresis, to one digitised input level per channel. Channels are grouped in banks of eight, and each bank follows the threshold pair of the mode that its own bank select bit names.

Top module: `hys_thr_ctrl`

## Requirements
- R1: After reset both modes hold low 2 and high 4. The word output reads 0x0206, `cfg_valid` and `req_err` are 0, `cfg_mode` is 0 and every channel state is 0.
- R2: An accepted request raises `cfg_valid` for exactly one cycle, on the clock edge that samples the strobe. In that cycle `cfg_mode` equals the requested mode and `cfg_word` equals {high−low, high+low} (bits 15:8 and 7:0) of the updated pair. `cfg_word` and `cfg_mode` hold between accepted requests.
- R3: A falling request (`req_rising`=0) is rejected when its value is below 2, above 21, or when value+2 exceeds the current high threshold of that mode.
- R4: A rising request (`req_rising`=1) is rejected when its value is below 3, above 22, or when it is less than the current low threshold of that mode plus 2.
- R5: When an accepted low update leaves high−low odd, the high threshold drops by 1. When an accepted high update leaves it odd, the low threshold rises by 1. An emitted word never has bit 8 set.
- R6: A legal request whose value equals the threshold it addresses produces no `cfg_valid` and no `req_err`, and changes no stored threshold.
- R7: A rejected request pulses `req_err` for one cycle, with `cfg_valid` low, and leaves both stored pairs unchanged.
- R8: For every emitted word, (bits 7:0 − bits 15:8)/2 equals the stored low threshold and (bits 7:0 + bits 15:8)/2 equals the stored high threshold.
- R9: On each clock a channel state becomes 1 when its level is at or above the high threshold. It becomes 0 when its level is at or below the low threshold. Otherwise it keeps its value.
- R10: Channels 8b to 8b+7 use the low/high thresholds of mode `bank_mode[b]` (0 = ground-open, 1 = supply-open).
- R11: A request addressed to one mode never changes the pair of the other mode.
- R12: In the cycle a threshold update is accepted, the comparators still use the thresholds stored before that edge. The new values apply from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Single-cycle strobe for a threshold change request |
| req_mode | input | 1 | Mode addressed: 0 ground-open, 1 supply-open |
| req_rising | input | 1 | 1 sets the high threshold, 0 sets the low threshold |
| req_value | input | 5 | Requested threshold in volts |
| bank_mode | input | 4 | Mode followed by each bank of eight channels |
| ch_level | input | 160 | Digitised level per channel, channel i at bits 5i+4:5i |
| cfg_valid | output | 1 | One-cycle pulse: a new configuration word is present |
| cfg_mode | output | 1 | Mode the configuration word belongs to |
| cfg_word | output | 16 | {high−low, high+low} of that mode |
| req_err | output | 1 | One-cycle pulse: the last request was rejected |
| ch_state | output | 32 | Hysteresis state per channel |

## Verification
A threshold update and a comparator decision can fall on the same clock edge. The comparator must then decide with the old pair while the register takes the new one. The bench provokes this in a directed sequence. The channel levels sit between the old and new high thresholds while a rising request lowers the high threshold. Random runs also do this constantly by changing levels and requests together. A reference model in the bench resolves every channel against the pre-edge thresholds before it applies the request, so a design that lets the new value leak into the same edge shows up as a channel-state mismatch.

// File: rtl/hys_pkg.sv
package hys_pkg;

  localparam int THR_W   = 5;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NMODE   = 2;

  localparam int FALL_MIN = 2;
  localparam int FALL_MAX = 21;
  localparam int RISE_MIN = 3;
  localparam int RISE_MAX = 22;
  localparam int HYS_MIN  = 2;
  localparam int INIT_LO  = 2;
  localparam int INIT_HI  = 4;

  typedef struct packed {
    logic [THR_W-1:0] lo;
    logic [THR_W-1:0] hi;
  } thr_pair_t;

  function automatic logic [WORD_W-1:0] pack_word(thr_pair_t t);
    logic [BYTE_W-1:0] sep;
    logic [BYTE_W-1:0] sum;
    sep = BYTE_W'(t.hi) - BYTE_W'(t.lo);
    sum = BYTE_W'(t.hi) + BYTE_W'(t.lo);
    return {sep, sum};
  endfunction

endpackage

// File: rtl/hys_thr_slot.sv
module hys_thr_slot
  import hys_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_en,
  input  logic             req_rising,
  input  logic [THR_W-1:0] req_value,
  output thr_pair_t        thr_q,
  output thr_pair_t        thr_d,
  output logic             accept,
  output logic             reject
);

  int v_i, lo_i, hi_i, nlo_i, nhi_i;

  always_comb begin
    v_i    = int'(req_value);
    lo_i   = int'(thr_q.lo);
    hi_i   = int'(thr_q.hi);
    nlo_i  = lo_i;
    nhi_i  = hi_i;
    accept = 1'b0;
    reject = 1'b0;
    if (req_en) begin
      if (!req_rising) begin
        if (v_i < FALL_MIN || v_i > FALL_MAX || (v_i + HYS_MIN) > hi_i) begin
          reject = 1'b1;
        end else if (v_i != lo_i) begin
          accept = 1'b1;
          nlo_i  = v_i;
          if (((nhi_i - nlo_i) & 1) != 0) nhi_i = nhi_i - 1;
        end
      end else begin
        if (v_i < RISE_MIN || v_i > RISE_MAX || v_i < (lo_i + HYS_MIN)) begin
          reject = 1'b1;
        end else if (v_i != hi_i) begin
          accept = 1'b1;
          nhi_i  = v_i;
          if (((nhi_i - nlo_i) & 1) != 0) nlo_i = nlo_i + 1;
        end
      end
    end
    thr_d.lo = THR_W'(nlo_i);
    thr_d.hi = THR_W'(nhi_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q.lo <= THR_W'(INIT_LO);
      thr_q.hi <= THR_W'(INIT_HI);
    end else if (accept) begin
      thr_q <= thr_d;
    end
  end

endmodule

// File: rtl/hys_cmp_bank.sv
module hys_cmp_bank
  import hys_pkg::*;
#(
  parameter int BANK_SZ = 8,
  parameter int LW      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANK_SZ*LW-1:0] level,
  input  thr_pair_t             thr,
  output logic [BANK_SZ-1:0]    state
);

  logic [BANK_SZ-1:0] state_d;

  for (genvar c = 0; c < BANK_SZ; c++) begin : g_ch
    always_comb begin
      if (int'(level[c*LW +: LW]) >= int'(thr.hi)) begin
        state_d[c] = 1'b1;
      end else if (int'(level[c*LW +: LW]) <= int'(thr.lo)) begin
        state_d[c] = 1'b0;
      end else begin
        state_d[c] = state[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_d;
  end

endmodule

// File: rtl/hys_thr_ctrl.sv
module hys_thr_ctrl
  import hys_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int BANK_SZ = 8,
  parameter int LW      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_mode,
  input  logic                       req_rising,
  input  logic [THR_W-1:0]           req_value,
  input  logic [NUM_CH/BANK_SZ-1:0]  bank_mode,
  input  logic [NUM_CH*LW-1:0]       ch_level,
  output logic                       cfg_valid,
  output logic                       cfg_mode,
  output logic [WORD_W-1:0]          cfg_word,
  output logic                       req_err,
  output logic [NUM_CH-1:0]          ch_state
);

  localparam int NBANK = NUM_CH / BANK_SZ;

  logic rst_meta, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  thr_pair_t        thr_q  [NMODE];
  thr_pair_t        thr_d  [NMODE];
  logic [NMODE-1:0] acc_m;
  logic [NMODE-1:0] rej_m;

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    hys_thr_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .req_en     (req_valid && (int'(req_mode) == m)),
      .req_rising (req_rising),
      .req_value  (req_value),
      .thr_q      (thr_q[m]),
      .thr_d      (thr_d[m]),
      .accept     (acc_m[m]),
      .reject     (rej_m[m])
    );
  end

  logic              valid_d, err_d, mode_d;
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    valid_d = |acc_m;
    err_d   = |rej_m;
    word_en = valid_d;
    mode_d  = req_mode;
    word_d  = pack_word(thr_d[req_mode]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_valid <= 1'b0;
      req_err   <= 1'b0;
    end else begin
      cfg_valid <= valid_d;
      req_err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_mode <= 1'b0;
      cfg_word <= pack_word('{lo: THR_W'(INIT_LO), hi: THR_W'(INIT_HI)});
    end else if (word_en) begin
      cfg_mode <= mode_d;
      cfg_word <= word_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    hys_cmp_bank #(.BANK_SZ(BANK_SZ), .LW(LW)) u_bank (
      .clk   (clk),
      .rst_n (rst_int_n),
      .level (ch_level[b*BANK_SZ*LW +: BANK_SZ*LW]),
      .thr   (thr_q[bank_mode[b]]),
      .state (ch_state[b*BANK_SZ +: BANK_SZ])
    );
  end

endmodule

// File: rtl/hys_thr_ctrl_chk.sv
module hys_thr_ctrl_chk
  import hys_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int BANK_SZ = 8,
  parameter int LW      = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_mode,
  input logic [NUM_CH*LW-1:0]      ch_level,
  input logic                      cfg_valid,
  input logic                      cfg_mode,
  input logic [WORD_W-1:0]         cfg_word,
  input logic                      req_err,
  input logic [NUM_CH-1:0]         ch_state
);

  p_err_no_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !cfg_valid);

  p_even_sep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !cfg_word[BYTE_W]);

  p_min_sep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (int'(cfg_word[WORD_W-1:BYTE_W]) >= HYS_MIN));

  p_err_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid));

  p_word_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ($past(req_valid) && ($past(req_mode) == cfg_mode)));

  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> ($stable(cfg_word) || $past(!rst_n)));

  p_set_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_state[0]) |-> (int'($past(ch_level[LW-1:0])) >= RISE_MIN));

  p_clr_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_state[0]) |-> (int'($past(ch_level[LW-1:0])) <= FALL_MAX));

endmodule

bind hys_thr_ctrl hys_thr_ctrl_chk #(.NUM_CH(NUM_CH), .BANK_SZ(BANK_SZ), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .ch_level  (ch_level),
  .cfg_valid (cfg_valid),
  .cfg_mode  (cfg_mode),
  .cfg_word  (cfg_word),
  .req_err   (req_err),
  .ch_state  (ch_state)
);

// File: tb/test_hys_thr_ctrl.sv
module test_hys_thr_ctrl;

  localparam int NCH = 32;
  localparam int LWB = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_mode, req_rising;
  logic [4:0]       req_value;
  logic [3:0]       bank_mode;
  logic [NCH*LWB-1:0] ch_level;
  logic             cfg_valid, cfg_mode, req_err;
  logic [15:0]      cfg_word;
  logic [NCH-1:0]   ch_state;

  always #4 clk = ~clk;

  hys_thr_ctrl i_hys_thr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_rising(req_rising), .req_value(req_value), .bank_mode(bank_mode),
    .ch_level(ch_level), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
    .cfg_word(cfg_word), .req_err(req_err), .ch_state(ch_state)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_lo [2];
  int m_hi [2];
  logic [NCH-1:0] e_state;
  logic e_valid, e_err, e_mode;
  logic [15:0] e_word;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] enc(input int lo, input int hi);
    return {8'(hi - lo), 8'(hi + lo)};
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin m_lo[m] = 2; m_hi[m] = 4; end
    e_state = '0; e_valid = 0; e_err = 0; e_mode = 0; e_word = 16'h0206;
  endtask

  task automatic step(input logic v, input logic md, input logic r, input int val,
                      input logic [3:0] bm, input logic [NCH*LWB-1:0] lv, input string tag);
    int lo, hi;
    req_valid = v; req_mode = md; req_rising = r; req_value = 5'(val);
    bank_mode = bm; ch_level = lv;
    for (int c = 0; c < NCH; c++) begin
      int sel, lvl;
      sel = int'(bm[c/8]);
      lvl = int'(lv[c*LWB +: LWB]);
      if (lvl >= m_hi[sel]) e_state[c] = 1'b1;
      else if (lvl <= m_lo[sel]) e_state[c] = 1'b0;
    end
    e_valid = 0; e_err = 0;
    if (v) begin
      lo = m_lo[md]; hi = m_hi[md];
      if (!r) begin
        if (val < 2 || val > 21 || val > hi - 2) e_err = 1;
        else if (val != lo) begin
          e_valid = 1; lo = val;
          if ((hi - lo) % 2 == 1) hi = hi - 1;
        end
      end else begin
        if (val < 3 || val > 22 || val < lo + 2) e_err = 1;
        else if (val != hi) begin
          e_valid = 1; hi = val;
          if ((hi - lo) % 2 == 1) lo = lo + 1;
        end
      end
      if (e_valid) begin
        m_lo[md] = lo; m_hi[md] = hi; e_word = enc(lo, hi); e_mode = md;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "cfg_valid (R2)", cfg_valid, e_valid);
    cmp(tag, "req_err (R7)", req_err, e_err);
    cmp(tag, "cfg_word (R2)", cfg_word, e_word);
    cmp(tag, "cfg_mode (R2)", cfg_mode, e_mode);
    cmp(tag, "ch_state (R9)", ch_state, e_state);
    if (cfg_valid && e_valid) begin
      int lb, hb;
      lb = int'(cfg_word[7:0]); hb = int'(cfg_word[15:8]);
      cmp("R8", "low readback", (lb - hb) / 2, m_lo[e_mode]);
      cmp("R8", "high readback", (lb + hb) / 2, m_hi[e_mode]);
    end
  endtask

  function automatic logic [NCH*LWB-1:0] flat(input int lvl);
    logic [NCH*LWB-1:0] x;
    for (int c = 0; c < NCH; c++) x[c*LWB +: LWB] = 5'(lvl);
    return x;
  endfunction

  function automatic logic [NCH*LWB-1:0] rnd_levels();
    logic [NCH*LWB-1:0] x;
    for (int c = 0; c < NCH; c++) x[c*LWB +: LWB] = 5'($urandom_range(0, 24));
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; req_mode = 0; req_rising = 0; req_value = '0;
    bank_mode = '0; ch_level = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    cmp("R1", "cfg_word", cfg_word, 16'h0206);
    cmp("R1", "cfg_valid", cfg_valid, 0);
    cmp("R1", "req_err", req_err, 0);
    cmp("R1", "ch_state", ch_state, 0);
    // R1 / R6: stored initial values confirmed by equal requests
    step(1, 1, 1, 4, 4'h0, flat(0), "R6");
    step(1, 0, 0, 2, 4'h0, flat(0), "R6");
    // R5: odd separation after a high update pulls low up
    step(1, 0, 1, 7, 4'h0, flat(0), "R5");
    cmp("R5", "word after rising 7", cfg_word, 16'h040A);
    // R5: odd separation after a low update pulls high down
    step(1, 0, 0, 4, 4'h0, flat(0), "R5");
    cmp("R5", "word after falling 4", cfg_word, 16'h020A);
    // R3 boundaries
    step(1, 0, 0, 5, 4'h0, flat(0), "R3");
    step(1, 0, 0, 1, 4'h0, flat(0), "R3");
    step(1, 0, 0, 22, 4'h0, flat(0), "R3");
    // R4 boundaries
    step(1, 0, 1, 23, 4'h0, flat(0), "R4");
    step(1, 0, 1, 5, 4'h0, flat(0), "R4");
    step(1, 1, 1, 22, 4'h0, flat(0), "R4");
    step(1, 1, 0, 21, 4'h0, flat(0), "R3");
    step(1, 1, 0, 20, 4'h0, flat(0), "R3");
    // R11: mode 1 updates left mode 0 at lo4 hi6
    step(1, 0, 1, 6, 4'h0, flat(0), "R11");
    cmp("R11", "mode0 untouched", req_err, 0);
    // R12: same-edge update and comparison
    step(1, 0, 1, 10, 4'h0, flat(0), "R12");
    step(0, 0, 0, 0, 4'h0, flat(7), "R12");
    step(1, 0, 1, 6, 4'h0, flat(7), "R12");
    cmp("R12", "old high used", ch_state, 0);
    step(0, 0, 0, 0, 4'h0, flat(7), "R12");
    cmp("R12", "new high used", ch_state, 32'hFFFF_FFFF);
    // R10: banks follow their own mode (mode1 lo20 hi22)
    step(0, 0, 0, 0, 4'b0101, flat(21), "R10");
    step(0, 0, 0, 0, 4'b1010, flat(5), "R10");
    // R9 / R7 random mix
    for (int i = 0; i < 4000; i++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 24), 4'($urandom_range(0, 15)), rnd_levels(), "R9");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule